// File: doc/BRIEF.md
# Radio Frame Scheduler with Channel Hopping and Link Statistics

This block sets the pace of a radio control link. A prescaled tick counter cuts time into fixed frames; with the default parameters a frame lasts 151 ticks of the system clock divided by 1024, about 20 ms at 8 MHz. At every frame boundary the block emits a one-cycle frame-start pulse and moves to the next radio channel. The channels come from a 15-frame schedule that is deliberately uneven, so the link spends more time on some channels than on others.

The rest of the system reports one transmit outcome per frame (`tx_fail`) and the latest received signal strength (`rssi`). Both are held for the whole frame and are sampled at its closing boundary. Every 50 frames, one second by default, the block closes a statistics window. It then publishes a record on parallel output fields, marked by a one-cycle valid strobe. The record holds the elapsed seconds as a hundreds byte and a 0..99 low part, the failures in the window, the longest run of back-to-back failures, the mean failures per second since the last clear, and the signal strength cut to its low five bits. If every frame of a window failed, the seconds count and the long-term totals are cleared.

Top module: `frame_hop_scheduler`

## Requirements
- R1: `frame_start` is high for exactly one clock cycle at every frame boundary. Consecutive pulses are FRAME_TICKS*PRESCALE clock cycles apart.
- R2: A hop index runs 0..14 and then returns to 0, advancing once per frame. At each boundary `chan_code` takes the value for the current index: 0x45 for indexes 0..4, 0x48 for 5..10 and 0x60 for 11..14. The first boundary after reset uses index 0.
- R3: `chan_code` changes only in the cycle where `frame_start` is high. `chan_change` pulses together with `frame_start` exactly when the new code differs from the previous one.
- R4: A failed frame adds one to the window failure count and extends the current failure run. A successful frame first folds the run into the window maximum and then clears the run. The reported maximum also includes a run still open at the end of the window.
- R5: After every 50 frames, `stat_valid` pulses once with a new record. The window failure count, the run and the maximum then restart from zero.
- R6: At each window close the seconds low part `stat_sec_lo` counts up. On passing 99 it returns to 0 and `stat_sec_hi` increases by one.
- R7: If all 50 frames of a window failed and the longest run is 50, the seconds, the running failure total and the averaging divisor return to zero. That record then reports 0 for seconds, failures, maximum run and average.
- R8: `stat_avg` is the running failure total divided by the number of seconds since the last clear, truncated to an integer. It is 0 when that number of seconds is 0.
- R9: `stat_rssi` equals bits 4..0 of `rssi` as sampled at the boundary that closed the window.
- R10: Immediately after reset, `frame_start`, `chan_change` and `stat_valid` are low and `chan_code` is 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fail | input | 1 | Outcome of the current frame's transmission, 1 = failed; sampled at the frame's end |
| rssi | input | RSSI_W | Received signal strength, sampled at the frame's end |
| frame_start | output | 1 | One-cycle pulse at each frame boundary |
| chan_code | output | 8 | Radio channel for the frame that is starting |
| chan_change | output | 1 | Pulse when the channel differs from the previous frame's |
| stat_valid | output | 1 | One-cycle strobe marking a new statistics record |
| stat_sec_hi | output | SEC_HI_W | Seconds, hundreds part |
| stat_sec_lo | output | 7 | Seconds, 0..99 part |
| stat_err | output | 6 | Failed frames in the closed window |
| stat_max_run | output | 6 | Longest consecutive failure run in the window |
| stat_avg | output | CNT_W | Mean failures per second since last clear |
| stat_rssi | output | RSSI_KEEP | Low bits of the received signal strength |

## Verification
On every cycle, the assertions check the following: the tick counter never reaches the frame length, the frame pulse is never two cycles wide, the channel is frozen between boundaries, and the hop index stays inside the 15-entry cycle. They also check that the run and failure counters never exceed the window size, that the seconds low part stays below 100, that window counters are cleared after a close, and that the divider's done pulse is isolated. Only the bench's scenarios can show the values that matter end to end. These are the exact channel sequence, the maximum run when it closes the window, the all-failed clear and its zero average, the carry of the seconds into the hundreds byte after 100 windows, and the truncated average against a model of the totals.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Which part of the uneven hop cycle a frame falls into
  typedef enum logic [1:0] {
    SEG_FIRST  = 2'd0,
    SEG_MIDDLE = 2'd1,
    SEG_LAST   = 2'd2
  } hop_seg_e;

  // Width helper that never returns zero
  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/fs_frame_timer.sv
module fs_frame_timer #(
  parameter int PRESCALE    = 1024,
  parameter int FRAME_TICKS = 151
) (
  input  logic clk,
  input  logic rst,
  output logic frame_end,
  output logic frame_start
);
  localparam int PW = fs_pkg::safe_clog2(PRESCALE);
  localparam int TW = fs_pkg::safe_clog2(FRAME_TICKS);

  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick      = (pre_cnt == PW'(PRESCALE - 1));
  assign frame_end = tick && (tick_cnt == TW'(FRAME_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt     <= '0;
      tick_cnt    <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= frame_end;
      pre_cnt     <= tick ? '0 : pre_cnt + 1'b1;
      if (frame_end)
        tick_cnt <= '0;
      else if (tick)
        tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // R1: tick counter stays below the frame length
  p_tick_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(tick_cnt) < FRAME_TICKS);

  // R1: the frame pulse never lasts two cycles
  p_pulse_width_r1: assert property (@(posedge clk) disable iff (rst)
    (PRESCALE * FRAME_TICKS > 1) && frame_start |=> !frame_start);
endmodule

// File: rtl/fs_hop_sched.sv
module fs_hop_sched #(
  parameter int         HOP_LEN   = 15,
  parameter int         SEG_A_LEN = 5,
  parameter int         SEG_B_END = 11,
  parameter logic [7:0] CH_A      = 8'h45,
  parameter logic [7:0] CH_B      = 8'h48,
  parameter logic [7:0] CH_C      = 8'h60,
  parameter logic [7:0] CH_RESET  = 8'h48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_end,
  output logic [7:0] chan_code,
  output logic       chan_change
);
  import fs_pkg::*;
  localparam int HW = safe_clog2(HOP_LEN);

  logic [HW-1:0] hop_idx;
  hop_seg_e      seg;
  logic [7:0]    next_code;

  always_comb begin
    if (int'(hop_idx) < SEG_A_LEN)
      seg = SEG_FIRST;
    else if (int'(hop_idx) < SEG_B_END)
      seg = SEG_MIDDLE;
    else
      seg = SEG_LAST;
    case (seg)
      SEG_FIRST:  next_code = CH_A;
      SEG_MIDDLE: next_code = CH_B;
      default:    next_code = CH_C;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hop_idx     <= '0;
      chan_code   <= CH_RESET;
      chan_change <= 1'b0;
    end else begin
      chan_change <= 1'b0;
      if (frame_end) begin
        hop_idx     <= (hop_idx == HW'(HOP_LEN - 1)) ? '0 : hop_idx + 1'b1;
        chan_code   <= next_code;
        chan_change <= (next_code != chan_code);
      end
    end
  end

  // R2: hop index stays inside the cycle
  p_hop_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(hop_idx) < HOP_LEN);

  // R3: channel frozen unless a boundary occurred
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(chan_code));
endmodule

// File: rtl/fs_link_stats.sv
module fs_link_stats #(
  parameter int WIN_FRAMES = 50,
  parameter int SEC_LO_MAX = 99,
  parameter int SEC_HI_W   = 8,
  parameter int CNT_W      = 16,
  parameter int RSSI_W     = 8,
  parameter int RSSI_KEEP  = 5,
  localparam int WW   = fs_pkg::safe_clog2(WIN_FRAMES + 1),
  localparam int LO_W = fs_pkg::safe_clog2(SEC_LO_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_end,
  input  logic                 tx_fail,
  input  logic [RSSI_W-1:0]    rssi,
  output logic [SEC_HI_W-1:0]  sec_hi,
  output logic [LO_W-1:0]      sec_lo,
  output logic [WW-1:0]        rec_err,
  output logic [WW-1:0]        rec_max,
  output logic [RSSI_KEEP-1:0] rec_rssi,
  output logic                 div_go,
  output logic [CNT_W-1:0]     div_num,
  output logic [CNT_W-1:0]     div_den
);
  logic [WW-1:0]    idx, win_err, run, max_run;
  logic [CNT_W-1:0] total, secs;

  logic [WW-1:0]       err_n, run_n, max_n, max_fin;
  logic                last, all_fail;
  logic [LO_W-1:0]     lo_n;
  logic [SEC_HI_W-1:0] hi_n;
  logic [CNT_W-1:0]    tot_n, secs_n;

  always_comb begin
    err_n    = win_err + WW'(tx_fail);
    run_n    = tx_fail ? run + 1'b1 : '0;
    max_n    = (!tx_fail && run > max_run) ? run : max_run;
    max_fin  = (run_n > max_n) ? run_n : max_n;
    last     = (idx == WW'(WIN_FRAMES - 1));
    all_fail = (err_n == WW'(WIN_FRAMES)) && (max_fin == WW'(WIN_FRAMES));
    if (sec_lo == LO_W'(SEC_LO_MAX)) begin
      lo_n = '0;
      hi_n = sec_hi + 1'b1;
    end else begin
      lo_n = sec_lo + 1'b1;
      hi_n = sec_hi;
    end
    tot_n  = total + CNT_W'(err_n);
    secs_n = secs + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      win_err  <= '0;
      run      <= '0;
      max_run  <= '0;
      total    <= '0;
      secs     <= '0;
      sec_hi   <= '0;
      sec_lo   <= '0;
      rec_err  <= '0;
      rec_max  <= '0;
      rec_rssi <= '0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
    end else begin
      div_go <= 1'b0;
      if (frame_end) begin
        if (last) begin
          idx      <= '0;
          win_err  <= '0;
          run      <= '0;
          max_run  <= '0;
          div_go   <= 1'b1;
          rec_rssi <= rssi[RSSI_KEEP-1:0];
          if (all_fail) begin
            sec_lo  <= '0;
            sec_hi  <= '0;
            total   <= '0;
            secs    <= '0;
            rec_err <= '0;
            rec_max <= '0;
            div_num <= '0;
            div_den <= '0;
          end else begin
            sec_lo  <= lo_n;
            sec_hi  <= hi_n;
            total   <= tot_n;
            secs    <= secs_n;
            rec_err <= err_n;
            rec_max <= max_fin;
            div_num <= tot_n;
            div_den <= secs_n;
          end
        end else begin
          idx     <= idx + 1'b1;
          win_err <= err_n;
          run     <= run_n;
          max_run <= max_n;
        end
      end
    end
  end

  // R4: run, maximum and window count bounded by the window size
  p_run_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(run) <= WIN_FRAMES && int'(max_run) <= WIN_FRAMES && int'(win_err) <= WIN_FRAMES);

  // R4: a failed frame inside a window grows the failure count by one
  p_err_step_r4: assert property (@(posedge clk) disable iff (rst)
    frame_end && tx_fail && !last |=> win_err == $past(win_err) + 1'b1);

  // R5: window counters restart after a close
  p_window_clear_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end && last |=> win_err == '0 && run == '0 && max_run == '0 && idx == '0);

  // R6: seconds low part never reaches 100
  p_lo_range_r6: assert property (@(posedge clk) disable iff (rst)
    int'(sec_lo) <= SEC_LO_MAX);
endmodule

// File: rtl/fs_divider.sv
module fs_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = fs_pkg::safe_clog2(W + 1);

  logic [W:0]    rem, shifted, diff, rem_nx;
  logic [W-1:0]  dvs, quo_nx;
  logic [CW-1:0] cnt;
  logic          busy;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    diff    = shifted - {1'b0, dvs};
    if (!diff[W]) begin
      rem_nx = diff;
      quo_nx = {quo[W-2:0], 1'b1};
    end else begin
      rem_nx = shifted;
      quo_nx = {quo[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        if (den == '0) begin
          quo  <= '0;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem  <= '0;
          quo  <= num;
          dvs  <= den;
          cnt  <= CW'(W);
          busy <= 1'b1;
        end
      end else if (busy) begin
        rem <= rem_nx;
        quo <= quo_nx;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8: a finished quotient is announced once and the divider is idle then
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done && !go |=> !done);
endmodule

// File: rtl/frame_hop_scheduler.sv
module frame_hop_scheduler #(
  parameter int         PRESCALE    = 1024,
  parameter int         FRAME_TICKS = 151,
  parameter int         HOP_LEN     = 15,
  parameter int         SEG_A_LEN   = 5,
  parameter int         SEG_B_END   = 11,
  parameter logic [7:0] CH_A        = 8'h45,
  parameter logic [7:0] CH_B        = 8'h48,
  parameter logic [7:0] CH_C        = 8'h60,
  parameter int         WIN_FRAMES  = 50,
  parameter int         SEC_LO_MAX  = 99,
  parameter int         SEC_HI_W    = 8,
  parameter int         CNT_W       = 16,
  parameter int         RSSI_W      = 8,
  parameter int         RSSI_KEEP   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_fail,
  input  logic [RSSI_W-1:0]    rssi,
  output logic                 frame_start,
  output logic [7:0]           chan_code,
  output logic                 chan_change,
  output logic                 stat_valid,
  output logic [SEC_HI_W-1:0]  stat_sec_hi,
  output logic [fs_pkg::safe_clog2(SEC_LO_MAX+1)-1:0] stat_sec_lo,
  output logic [fs_pkg::safe_clog2(WIN_FRAMES+1)-1:0] stat_err,
  output logic [fs_pkg::safe_clog2(WIN_FRAMES+1)-1:0] stat_max_run,
  output logic [CNT_W-1:0]     stat_avg,
  output logic [RSSI_KEEP-1:0] stat_rssi
);
  logic             frame_end;
  logic             div_go;
  logic [CNT_W-1:0] div_num, div_den;

  fs_frame_timer #(.PRESCALE(PRESCALE), .FRAME_TICKS(FRAME_TICKS)) u_timer (
    .clk(clk), .rst(rst), .frame_end(frame_end), .frame_start(frame_start));

  fs_hop_sched #(.HOP_LEN(HOP_LEN), .SEG_A_LEN(SEG_A_LEN), .SEG_B_END(SEG_B_END),
                 .CH_A(CH_A), .CH_B(CH_B), .CH_C(CH_C), .CH_RESET(CH_B)) u_hop (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .chan_code(chan_code), .chan_change(chan_change));

  fs_link_stats #(.WIN_FRAMES(WIN_FRAMES), .SEC_LO_MAX(SEC_LO_MAX), .SEC_HI_W(SEC_HI_W),
                  .CNT_W(CNT_W), .RSSI_W(RSSI_W), .RSSI_KEEP(RSSI_KEEP)) u_stats (
    .clk(clk), .rst(rst), .frame_end(frame_end), .tx_fail(tx_fail), .rssi(rssi),
    .sec_hi(stat_sec_hi), .sec_lo(stat_sec_lo), .rec_err(stat_err), .rec_max(stat_max_run),
    .rec_rssi(stat_rssi), .div_go(div_go), .div_num(div_num), .div_den(div_den));

  fs_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .quo(stat_avg), .done(stat_valid));

  // R3: the channel only moves together with the frame pulse
  p_chan_at_frame_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(chan_code));
  p_change_with_frame_r3: assert property (@(posedge clk) disable iff (rst)
    chan_change |-> frame_start);
endmodule

// File: tb/frame_hop_scheduler_bench.sv
module frame_hop_scheduler_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int PRESCALE    = 2;
  localparam int FRAME_TICKS = 4;
  localparam int FRAME_CYC   = PRESCALE * FRAME_TICKS;
  localparam int WIN         = 50;
  localparam int N_WINDOWS   = 105;
  localparam int WATCHDOG    = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_fail = 1'b0;
  logic [7:0] rssi = 8'h00;
  logic frame_start, chan_change, stat_valid;
  logic [7:0] chan_code, stat_sec_hi;
  logic [6:0] stat_sec_lo;
  logic [5:0] stat_err, stat_max_run;
  logic [15:0] stat_avg;
  logic [4:0] stat_rssi;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_hop_scheduler #(.PRESCALE(PRESCALE), .FRAME_TICKS(FRAME_TICKS)) u_frame_hop_scheduler (
    .clk(clk), .rst(rst), .tx_fail(tx_fail), .rssi(rssi),
    .frame_start(frame_start), .chan_code(chan_code), .chan_change(chan_change),
    .stat_valid(stat_valid), .stat_sec_hi(stat_sec_hi), .stat_sec_lo(stat_sec_lo),
    .stat_err(stat_err), .stat_max_run(stat_max_run), .stat_avg(stat_avg),
    .stat_rssi(stat_rssi));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model state
  int m_idx = 0, m_err = 0, m_run = 0, m_max = 0, m_hop = 0;
  int m_lo = 0, m_hi = 0, m_secs = 0, m_tot = 0, win_cnt = 0;
  int m_code = 8'h48;
  int e_hi, e_lo, e_err, e_max, e_avg, e_rssi;
  bit pending = 0;

  function automatic int hop_code(input int h);
    if (h < 5) return 8'h45;
    else if (h <= 10) return 8'h48;
    else return 8'h60;
  endfunction

  function automatic bit pick_fail(input int w, input int i);
    case (w)
      0: return ($urandom % 10) < 3;
      1: return 1'b0;
      2: return 1'b1;
      3: return i < 49;
      4: return i >= 40;
      default: return ($urandom % 100) < 5;
    endcase
  endfunction

  task automatic model_frame(input bit f, input int r);
    int fin;
    if (f) begin m_err++; m_run++; end
    else begin if (m_run > m_max) m_max = m_run; m_run = 0; end
    if (m_idx == WIN - 1) begin
      fin = (m_run > m_max) ? m_run : m_max;
      m_lo++;
      if (m_lo > 99) begin m_hi = (m_hi + 1) % 256; m_lo = 0; end
      m_secs++;
      m_tot += m_err;
      if (m_err == WIN && fin == WIN) begin
        m_hi = 0; m_lo = 0; m_tot = 0; m_secs = 0; e_err = 0; e_max = 0;
      end else begin
        e_err = m_err; e_max = fin;
      end
      e_avg  = (m_secs != 0) ? (m_tot / m_secs) : 0;
      e_hi   = m_hi; e_lo = m_lo; e_rssi = r & 31;
      pending = 1;
      m_err = 0; m_run = 0; m_max = 0; m_idx = 0;
      win_cnt++;
    end else m_idx++;
  endtask

  initial begin
    int cyc = 0, last_fs = -1, seedv;
    bit done = 0;
    seedv = $urandom(32'h5EED_1234);
    tx_fail = pick_fail(0, 0);
    rssi = 8'($urandom);
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(frame_start == 0, "R10", "frame_start in reset", frame_start, 0);
    chk(chan_code == 8'h48, "R10", "chan_code in reset", chan_code, 8'h48);
    chk(chan_change == 0, "R10", "chan_change in reset", chan_change, 0);
    chk(stat_valid == 0, "R10", "stat_valid in reset", stat_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(chan_code == 8'h48 && !frame_start, "R10", "chan_code after release", chan_code, 8'h48);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(0, "R5", "watchdog expired", cyc, WATCHDOG);
        done = 1;
      end
      if (stat_valid) begin
        chk(pending, "R5", "record without window close", 1, int'(pending));
        chk(stat_sec_hi == e_hi, "R6", "seconds hundreds", stat_sec_hi, e_hi);
        chk(stat_sec_lo == e_lo, "R6", "seconds low", stat_sec_lo, e_lo);
        chk(stat_err == e_err, "R4", "window failures", stat_err, e_err);
        chk(stat_max_run == e_max, "R4", "max run", stat_max_run, e_max);
        chk(stat_avg == e_avg, "R8", "average", stat_avg, e_avg);
        chk(stat_rssi == e_rssi, "R9", "rssi low bits", stat_rssi, e_rssi);
        if (win_cnt == 3)
          chk(stat_err == 0 && stat_avg == 0 && stat_sec_lo == 0, "R7",
              "all-failed window clears", stat_err, 0);
        pending = 0;
        if (win_cnt >= N_WINDOWS) done = 1;
      end
      if (frame_start) begin
        if (last_fs >= 0)
          chk(cyc - last_fs == FRAME_CYC, "R1", "frame interval", cyc - last_fs, FRAME_CYC);
        last_fs = cyc;
        model_frame(tx_fail, int'(rssi));
        chk(chan_code == hop_code(m_hop), "R2", "channel code", chan_code, hop_code(m_hop));
        chk(chan_change == (hop_code(m_hop) != m_code), "R3", "channel change",
            chan_change, int'(hop_code(m_hop) != m_code));
        m_code = hop_code(m_hop);
        m_hop = (m_hop == 14) ? 0 : m_hop + 1;
        tx_fail = pick_fail(win_cnt, m_idx);
        rssi = 8'($urandom);
      end else if (last_fs >= 0) begin
        chk(!chan_change, "R3", "change outside frame", chan_change, 0);
      end
    end
    chk(win_cnt == N_WINDOWS, "R6", "windows completed", win_cnt, N_WINDOWS);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule